// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block decides whether a received frame is kept, using only its 48-bit destination address. The address arrives one byte per accepted beat, first byte first, on a valid/ready stream. A start strobe travels with the first byte. Once the sixth byte is taken, the block issues a single-cycle decision pulse that carries an accept flag.

Unicast destinations are matched exactly against a small table of station addresses. Multicast destinations are checked against a bin table, indexed by a CRC-32 hash of the address. Several mode bits override both checks:

- promiscuous
- receive-all
- pass-all-multicast
- broadcast-disable

A plain register write port loads the mode word, the hash words and the station table.

Back-pressure rules:

- The block holds `da_ready` low during reset and high at all other times. A byte counts only in a cycle where both `da_valid` and `da_ready` are high. Idle cycles between bytes are allowed.
- The decision output has no ready signal. The consumer must take `dec_valid` in the cycle in which it is asserted.

Top module: `rx_addr_filter`

## Requirements
- R1: While `rst_n` is low, `dec_valid` and `da_ready` are 0 and the mode word, hash words and station entries other than entry 0 are cleared. `da_ready` is 1 from the first clock edge after reset is released.
- R2: A beat with `da_first` high starts a new address and discards any partial one. `dec_valid` is high for exactly the one cycle after the clock edge that takes the sixth byte, and cycles without `da_valid` do not count. Beats before the first strobe, and beats after the sixth byte, are ignored until the next strobe.
- R3: The address bytes are numbered 0 to 5 in arrival order. Station entry i has a low word at register 16+2i, holding byte 0 in bits 7:0 up to byte 3 in bits 31:24. It has a high word at register 17+2i, holding byte 4 in bits 7:0, byte 5 in bits 15:8 and an enable flag in bit 31. Entry 0 is always enabled. A unicast destination is accepted only when it equals an enabled entry.
- R4: A destination is multicast when bit 0 of byte 0 is 1. The hash is a reflected CRC-32 (polynomial 0xEDB88320, register preset to all ones, each byte fed least significant bit first) over the six bytes. The result is complemented and bit-reversed, and its top HASH_BITS bits (6, 7 or 8) form the bin index. The index bits above bit 4 pick the hash word at register 8+w, and the low 5 bits pick the bit within it. With hash mode on, a multicast frame is accepted only when that bit is 1.
- R5: A non-broadcast multicast destination is rejected when neither hash mode nor pass-all-multicast is set.
- R6: Mode bit 1 (pass-all-multicast) accepts every non-broadcast multicast destination without looking at the hash.
- R7: Mode bit 0 (promiscuous) accepts every destination whatever the other settings are.
- R8: Mode bit 4 (receive-all) accepts every destination whatever the other settings are.
- R9: The all-ones destination is accepted unless mode bit 3 (broadcast-disable) is set. In that case it is rejected even with pass-all-multicast, unless promiscuous or receive-all is set. Mode bit 2 is hash mode, and the mode word sits at register 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Register index |
| cfg_wdata | input | 32 | Register write data |
| da_valid | input | 1 | Address byte valid |
| da_ready | output | 1 | Filter can take a byte |
| da_first | input | 1 | Beat carries byte 0 of a new address |
| da_byte | input | 8 | Address byte |
| dec_valid | output | 1 | Decision pulse |
| dec_accept | output | 1 | Frame accepted (meaningful with dec_valid) |

## Verification
The decision is due one cycle after the edge that takes the sixth byte. The bench drives every byte on a falling edge and samples on the falling edge that follows the sixth byte's rising edge, then samples again one cycle later to confirm the pulse has dropped. Register writes take effect at the rising edge after they are driven, so every write completes before the first byte of the next address. For the tests of ignored bytes, the bench samples `dec_valid` on every falling edge across the stray beats.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;

  // mode word bit order: 4 recv_all, 3 bcast_dis, 2 hash_en, 1 pass_mc, 0 promisc
  typedef struct packed {
    logic recv_all;
    logic bcast_dis;
    logic hash_en;
    logic pass_mc;
    logic promisc;
  } filt_mode_t;

  function automatic logic [31:0] crc_byte(input logic [31:0] c_in, input logic [7:0] b);
    logic [31:0] c;
    c = c_in ^ {24'd0, b};
    for (int k = 0; k < 8; k++) begin
      c = c[0] ? ((c >> 1) ^ CRC_POLY_REFL) : (c >> 1);
    end
    return c;
  endfunction

endpackage

// File: rtl/rxf_regs.sv
module rxf_regs #(
  parameter int NUM_STATIONS = 4,
  parameter int HASH_WORDS   = 2,
  parameter int ADDR_W       = 6
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               we,
  input  logic [ADDR_W-1:0]                  addr,
  input  logic [31:0]                        wdata,
  output rxf_pkg::filt_mode_t                mode,
  output logic [HASH_WORDS-1:0][31:0]        hash,
  output logic [NUM_STATIONS-1:0][47:0]      st_mac,
  output logic [NUM_STATIONS-1:0]            st_en
);
  localparam int MODE_REG  = 0;
  localparam int HASH_BASE = 8;
  localparam int ST_BASE   = 16;

  always_ff @(posedge clk) begin
    if (!rst_n) mode <= '0;
    else if (we && addr == ADDR_W'(MODE_REG)) mode <= wdata[4:0];
  end

  for (genvar w = 0; w < HASH_WORDS; w++) begin : g_hash
    always_ff @(posedge clk) begin
      if (!rst_n) hash[w] <= '0;
      else if (we && addr == ADDR_W'(HASH_BASE + w)) hash[w] <= wdata;
    end
  end

  for (genvar s = 0; s < NUM_STATIONS; s++) begin : g_st
    logic [31:0] lo_q;
    logic [15:0] hi_q;
    logic        en_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lo_q <= '0;
        hi_q <= '0;
        en_q <= 1'b0;
      end else if (we && addr == ADDR_W'(ST_BASE + 2 * s)) begin
        lo_q <= wdata;
      end else if (we && addr == ADDR_W'(ST_BASE + 2 * s + 1)) begin
        hi_q <= wdata[15:0];
        en_q <= wdata[31];
      end
    end
    assign st_mac[s] = {lo_q[7:0], lo_q[15:8], lo_q[23:16], lo_q[31:24], hi_q[7:0], hi_q[15:8]};
    if (s == 0) begin : g_prim
      assign st_en[s] = 1'b1;
    end else begin : g_extra
      assign st_en[s] = en_q;
    end
  end

endmodule

// File: rtl/rxf_collect.sv
module rxf_collect (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic        in_first,
  input  logic [7:0]  in_byte,
  output logic        in_ready,
  output logic        done,
  output logic [31:0] crc_next,
  output logic [47:0] addr_next
);
  localparam int ADDR_BYTES = 6;
  localparam int CNT_W      = $clog2(ADDR_BYTES + 1);

  logic [CNT_W-1:0] cnt_q, cnt_eff;
  logic [31:0]      crc_q, crc_eff;
  logic [47:0]      sr_q, sr_eff;
  logic             beat, take;

  always_comb begin
    beat      = in_valid && in_ready;
    cnt_eff   = in_first ? '0 : cnt_q;
    crc_eff   = in_first ? '1 : crc_q;
    sr_eff    = in_first ? '0 : sr_q;
    take      = beat && (cnt_eff != CNT_W'(ADDR_BYTES));
    crc_next  = rxf_pkg::crc_byte(crc_eff, in_byte);
    addr_next = {sr_eff[39:0], in_byte};
    done      = take && (cnt_eff == CNT_W'(ADDR_BYTES - 1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_ready <= 1'b0;
      cnt_q    <= CNT_W'(ADDR_BYTES);
      crc_q    <= '1;
      sr_q     <= '0;
    end else begin
      in_ready <= 1'b1;
      if (take) begin
        cnt_q <= cnt_eff + 1'b1;
        crc_q <= crc_next;
        sr_q  <= addr_next;
      end
    end
  end

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(ADDR_BYTES));

  // R2
  restart_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && in_first) |=> (cnt_q == CNT_W'(1)));

endmodule

// File: rtl/rxf_decide.sv
module rxf_decide #(
  parameter int NUM_STATIONS = 4,
  parameter int HASH_BITS    = 6,
  parameter int HASH_WORDS   = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          done,
  input  logic [47:0]                   addr,
  input  logic [31:0]                   crc,
  input  rxf_pkg::filt_mode_t           mode,
  input  logic [HASH_WORDS-1:0][31:0]   hash,
  input  logic [NUM_STATIONS-1:0][47:0] st_mac,
  input  logic [NUM_STATIONS-1:0]       st_en,
  output logic                          dec_valid,
  output logic                          dec_accept
);
  localparam int WSEL_W = HASH_BITS - 5;

  logic [HASH_BITS-1:0] idx;
  logic [WSEL_W-1:0]    wsel;
  logic [4:0]           bsel;
  logic                 is_mc, is_bc, hash_hit, st_hit, verdict;

  always_comb begin
    for (int k = 0; k < HASH_BITS; k++) idx[HASH_BITS-1-k] = ~crc[k];
    wsel     = idx[HASH_BITS-1:5];
    bsel     = idx[4:0];
    hash_hit = hash[wsel][bsel];
    is_mc    = addr[40];
    is_bc    = &addr;
    st_hit   = 1'b0;
    for (int s = 0; s < NUM_STATIONS; s++)
      if (st_en[s] && st_mac[s] == addr) st_hit = 1'b1;
    if (mode.recv_all || mode.promisc) verdict = 1'b1;
    else if (is_bc)                    verdict = !mode.bcast_dis;
    else if (is_mc)                    verdict = mode.pass_mc || (mode.hash_en && hash_hit);
    else                               verdict = st_hit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
    end else begin
      dec_valid  <= done;
      dec_accept <= done && verdict;
    end
  end

  // R7 R8
  override_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (mode.promisc || mode.recv_all)) |=> dec_accept);

  // R9
  bcast_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && is_bc && mode.bcast_dis && !mode.promisc && !mode.recv_all) |=> !dec_accept);

  // R4
  hash_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && is_mc && !is_bc && !hash_hit && !mode.pass_mc && !mode.promisc && !mode.recv_all)
      |=> !dec_accept);

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter #(
  parameter int NUM_STATIONS = 4,
  parameter int HASH_BITS    = 6,
  parameter int ADDR_W       = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              da_valid,
  output logic              da_ready,
  input  logic              da_first,
  input  logic [7:0]        da_byte,
  output logic              dec_valid,
  output logic              dec_accept
);
  localparam int HASH_WORDS = 1 << (HASH_BITS - 5);

  rxf_pkg::filt_mode_t                mode;
  logic [HASH_WORDS-1:0][31:0]        hash;
  logic [NUM_STATIONS-1:0][47:0]      st_mac;
  logic [NUM_STATIONS-1:0]            st_en;
  logic                               done;
  logic [31:0]                        crc_next;
  logic [47:0]                        addr_next;

  rxf_regs #(.NUM_STATIONS(NUM_STATIONS), .HASH_WORDS(HASH_WORDS), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .mode(mode), .hash(hash), .st_mac(st_mac), .st_en(st_en)
  );

  rxf_collect u_collect (
    .clk(clk), .rst_n(rst_n), .in_valid(da_valid), .in_first(da_first), .in_byte(da_byte),
    .in_ready(da_ready), .done(done), .crc_next(crc_next), .addr_next(addr_next)
  );

  rxf_decide #(.NUM_STATIONS(NUM_STATIONS), .HASH_BITS(HASH_BITS), .HASH_WORDS(HASH_WORDS)) u_decide (
    .clk(clk), .rst_n(rst_n), .done(done), .addr(addr_next), .crc(crc_next), .mode(mode),
    .hash(hash), .st_mac(st_mac), .st_en(st_en), .dec_valid(dec_valid), .dec_accept(dec_accept)
  );

  // R2
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> !dec_valid);

endmodule

// File: tb/rx_addr_filter_bench.sv
module rx_addr_filter_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [5:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic da_valid = 1'b0, da_first = 1'b0;
  logic [7:0] da_byte = '0;
  logic da_ready, dec_valid, dec_accept;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  rx_addr_filter u_rx_addr_filter (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .da_valid(da_valid), .da_ready(da_ready), .da_first(da_first), .da_byte(da_byte),
    .dec_valid(dec_valid), .dec_accept(dec_accept)
  );

  localparam logic [47:0] S0 = 48'h02_11_22_33_44_55;
  localparam logic [47:0] S1 = 48'h02_AA_BB_CC_DD_EE;
  localparam logic [47:0] S2 = 48'h02_12_34_56_78_9A;
  localparam logic [47:0] UX = 48'h02_00_00_00_00_99;
  localparam logic [47:0] M1 = 48'h01_00_5E_00_00_01;
  localparam logic [47:0] M2 = 48'h01_00_5E_7F_00_22;
  localparam logic [47:0] BC = 48'hFF_FF_FF_FF_FF_FF;

  // {req[3:0], mode[4:0], da[47:0], exp[1:0]}; exp 2 = bench hash lookup
  localparam int NV = 15;
  localparam logic [58:0] VEC [NV] = '{
    {4'd3, 5'b00000, S0, 2'd1},  // R3 primary entry
    {4'd3, 5'b00000, S1, 2'd1},  // R3 enabled extra entry
    {4'd3, 5'b00000, S2, 2'd0},  // R3 disabled entry
    {4'd3, 5'b00000, UX, 2'd0},  // R3 no match
    {4'd4, 5'b00100, M1, 2'd1},  // R4 hash hit
    {4'd4, 5'b00100, M2, 2'd2},  // R4 hash lookup
    {4'd5, 5'b00000, M1, 2'd0},  // R5 no multicast mode
    {4'd6, 5'b00010, M2, 2'd1},  // R6 pass all multicast
    {4'd7, 5'b00001, UX, 2'd1},  // R7 promiscuous unicast
    {4'd7, 5'b00001, M2, 2'd1},  // R7 promiscuous multicast
    {4'd8, 5'b10000, UX, 2'd1},  // R8 receive all
    {4'd9, 5'b00000, BC, 2'd1},  // R9 broadcast default
    {4'd9, 5'b01000, BC, 2'd0},  // R9 broadcast disabled
    {4'd9, 5'b01010, BC, 2'd0},  // R9 disabled beats pass-all
    {4'd7, 5'b01001, BC, 2'd1}   // R7 promiscuous beats disable
  };

  function automatic logic [5:0] hidx(input logic [47:0] da);
    logic [31:0] c, r;
    logic fb;
    c = '1;
    for (int b = 0; b < 6; b++)
      for (int i = 0; i < 8; i++) begin
        fb = c[0] ^ da[47 - 8*b - 7 + i];
        c = c >> 1;
        if (fb) c = c ^ 32'hEDB88320;
      end
    c = ~c;
    for (int i = 0; i < 32; i++) r[31-i] = c[i];
    return r[31:26];
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 6'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_station(input int i, input logic [47:0] da, input logic en);
    wr(16 + 2*i, {da[23:16], da[31:24], da[39:32], da[47:40]});
    wr(17 + 2*i, {en, 15'd0, da[7:0], da[15:8]});
  endtask

  // sends one address; returns decision sampled one cycle after the sixth beat
  task automatic send(input logic [47:0] da, input int gap, output logic v, output logic a,
                      output logic v_next);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      da_valid = 1'b1; da_first = (i == 0); da_byte = da[47 - 8*i -: 8];
      if (gap > 0 && i < 5) begin
        @(negedge clk);
        da_valid = 1'b0; da_first = 1'b0;
        repeat (gap - 1) @(negedge clk);
      end
    end
    @(negedge clk);
    da_valid = 1'b0; da_first = 1'b0;
    v = dec_valid; a = dec_accept;
    @(negedge clk);
    v_next = dec_valid;
  endtask

  task automatic raw(input logic [7:0] b, input logic f, inout int seen);
    @(negedge clk);
    if (dec_valid) seen++;
    da_valid = 1'b1; da_first = f; da_byte = b;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic v, a, vn, e;
    logic [5:0] i1;
    int seen;
    repeat (4) @(negedge clk);
    check("R1 dec_valid in reset", dec_valid, 1'b0);
    check("R1 da_ready in reset", da_ready, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 da_ready after reset", da_ready, 1'b1);
    check("R1 dec_valid after reset", dec_valid, 1'b0);

    // R2: beats before any start strobe are ignored
    seen = 0;
    for (int k = 0; k < 7; k++) raw(8'(k), 1'b0, seen);
    @(negedge clk); if (dec_valid) seen++;
    da_valid = 1'b0;
    @(negedge clk); if (dec_valid) seen++;
    check("R2 no decision before strobe", seen != 0, 1'b0);

    set_station(0, S0, 1'b0);
    set_station(1, S1, 1'b1);
    set_station(2, S2, 1'b0);
    i1 = hidx(M1);
    wr(8 + i1[5], 32'(1) << i1[4:0]);

    for (int n = 0; n < NV; n++) begin
      string tag;
      wr(0, {27'd0, VEC[n][54:50]});
      send(VEC[n][49:2], 0, v, a, vn);
      e = (VEC[n][1:0] == 2'd2) ? (hidx(M2) == i1) : VEC[n][0];
      tag = $sformatf("R%0d vector %0d", VEC[n][58:55], n);
      check({tag, " valid"}, v, 1'b1);
      check({tag, " accept"}, a, e);
      check({tag, " pulse"}, vn, 1'b0);
    end

    // R2: idle cycles between bytes
    wr(0, 32'd0);
    send(S0, 3, v, a, vn);
    check("R2 gapped valid", v, 1'b1);
    check("R2 gapped accept", a, 1'b1);
    check("R2 gapped pulse", vn, 1'b0);

    // R2: bytes after the sixth are ignored
    seen = 0;
    for (int k = 0; k < 6; k++) raw(8'hFF, 1'b0, seen);
    @(negedge clk); if (dec_valid) seen++;
    da_valid = 1'b0;
    @(negedge clk); if (dec_valid) seen++;
    check("R2 extra bytes ignored", seen != 0, 1'b0);

    // R2: strobe in mid address restarts
    seen = 0;
    for (int k = 0; k < 3; k++) raw(UX[47 - 8*k -: 8], k == 0, seen);
    send(S1, 0, v, a, vn);
    check("R2 restart valid", v, 1'b1);
    check("R2 restart accept", a, 1'b1);

    // R3: enabling station entry 2
    set_station(2, S2, 1'b1);
    send(S2, 0, v, a, vn);
    check("R3 entry enabled accept", a, 1'b1);

    // R4: hash mode with hash words cleared rejects the former hit
    wr(0, 32'h4);
    wr(8 + i1[5], 32'd0);
    send(M1, 0, v, a, vn);
    check("R4 cleared bin reject", a, 1'b0);

    finish_run();
  end
endmodule